// File: doc/BRIEF.md
# Serial Link Hot-Plug Reset Controller

This controller watches a serial storage link for a device being attached or removed. It has two states. In the reset state it sends a one-cycle link reset request at a fixed interval and waits for the device to answer with its init signal. When the device answers while the physical layer reports ready, the controller moves to the ready state and normal traffic can proceed.

In the ready state a short silence timer watches the line. Every cycle with valid line activity restarts the timer. If the line stays quiet for the full timeout, or the physical layer drops its ready indication, the controller goes back to the reset state and restarts the request sequence. That first request goes out on the very next cycle.

Each change of the ready flag, in either direction, sets a sticky change flag. Software clears the flag by writing a 1. An enable bit decides whether the flag drives the interrupt output. Both timer lengths are parameters counted in clock cycles. At 250 MHz the defaults give 100 ms between requests and a 200 ns silence timeout.

Top module: `link_hotplug_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `link_ready`, `chg_flag` and `irq_o` are 0. `reset_req` is 0 while reset is held. It is 1 for one cycle right after the first clock edge with reset released.
- R2: In the reset state `reset_req` pulses for exactly one cycle every RETRY_CYC cycles, counted from the previous pulse.
- R3: In the reset state, a clock edge that samples `init_seen`=1 and `phy_ok`=1 sets `link_ready` at that edge. That edge issues no `reset_req` pulse, even when it falls in a pulse slot. `init_seen` with `phy_ok`=0 leaves the controller in the reset state.
- R4: In the ready state, any cycle with `line_active`=1 restarts the silence count. `link_ready` falls at the edge that samples the SIL_CYC-th consecutive cycle with `line_active`=0. It stays 1 after fewer quiet cycles.
- R5: In the ready state, an edge that samples `phy_ok`=0 clears `link_ready` at that edge.
- R6: After the reset state is re-entered from the ready state, `reset_req` pulses on the next edge. It then pulses every RETRY_CYC cycles.
- R7: Every change of `link_ready`, rising or falling, sets `chg_flag` at the same edge.
- R8: `chg_flag` stays 1 until an edge samples `irq_clr`=1. If a change of `link_ready` happens at the same edge as a clear, the flag stays set.
- R9: `irq_o` equals `chg_flag` when `irq_en`=1 and is 0 when `irq_en`=0. `irq_en` has no effect on `chg_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_active | input | 1 | Valid signal seen on the line this cycle |
| init_seen | input | 1 | Device init response received |
| phy_ok | input | 1 | Physical layer reports ready |
| irq_en | input | 1 | Interrupt enable for the change flag |
| irq_clr | input | 1 | Write-1 clear of the change flag |
| reset_req | output | 1 | One-cycle link reset request |
| link_ready | output | 1 | Controller is in the ready state |
| chg_flag | output | 1 | Sticky ready-change status |
| irq_o | output | 1 | Masked ready-change interrupt |

## Verification
The bench builds the controller with RETRY_CYC=6 and SIL_CYC=4. These short values make it possible to sweep every retry phase for the arrival of the init response, including the phase where it meets a pulse slot. They also allow every silence length from one cycle to one past the timeout. Every combination of prior flag, clear, same-cycle change and enable is tried, and each combination starts from a fresh reset.

// File: rtl/link_hotplug_ctrl.sv
module link_hotplug_ctrl #(
  parameter int unsigned RETRY_CYC = 25_000_000,
  parameter int unsigned SIL_CYC   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_active,
  input  logic init_seen,
  input  logic phy_ok,
  input  logic irq_en,
  input  logic irq_clr,
  output logic reset_req,
  output logic link_ready,
  output logic chg_flag,
  output logic irq_o
);
  localparam int RW = $clog2(RETRY_CYC + 1);
  localparam int SW = $clog2(SIL_CYC + 1);
  localparam logic [RW-1:0] RLAST = RW'(RETRY_CYC - 1);
  localparam logic [SW-1:0] SLAST = SW'(SIL_CYC - 1);

  typedef enum logic {ST_CR, ST_RDY} st_t;
  st_t st, st_nx;

  logic [RW-1:0] rcnt;
  logic [SW-1:0] scnt;

  wire in_cr   = (st == ST_CR);
  wire in_rdy  = (st == ST_RDY);
  wire go_rdy  = in_cr && init_seen && phy_ok;
  wire quiet   = in_rdy && !line_active && (scnt == SLAST);
  wire go_cr   = in_rdy && (!phy_ok || quiet);

  always_comb begin
    st_nx = st;
    if (go_rdy)     st_nx = ST_RDY;
    else if (go_cr) st_nx = ST_CR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_CR;
      rcnt      <= '0;
      scnt      <= '0;
      reset_req <= 1'b0;
      chg_flag  <= 1'b0;
    end else begin
      st        <= st_nx;
      reset_req <= in_cr && (rcnt == '0) && !go_rdy;
      if (in_cr && !go_rdy)
        rcnt <= (rcnt == RLAST) ? '0 : rcnt + 1'b1;
      else
        rcnt <= '0;
      if (in_rdy && !line_active && !go_cr)
        scnt <= scnt + 1'b1;
      else
        scnt <= '0;
      chg_flag  <= (st_nx != st) || (chg_flag && !irq_clr);
    end
  end

  assign link_ready = in_rdy;
  assign irq_o      = chg_flag & irq_en;
endmodule

// File: rtl/link_hotplug_ctrl_chk.sv
module link_hotplug_ctrl_chk #(
  parameter int unsigned RETRY_CYC = 25_000_000,
  parameter int unsigned SIL_CYC   = 50
) (
  input logic clk,
  input logic rst_n,
  input logic line_active,
  input logic init_seen,
  input logic phy_ok,
  input logic irq_en,
  input logic irq_clr,
  input logic reset_req,
  input logic link_ready,
  input logic chg_flag,
  input logic irq_o
);
  localparam int QW = $clog2(SIL_CYC + 2) + 1;
  localparam logic [QW-1:0] QLIM = QW'(SIL_CYC);

  logic [QW-1:0] qn;
  always_ff @(posedge clk) begin
    if (!rst_n) qn <= '0;
    else if (link_ready && !line_active) qn <= qn + 1'b1;
    else qn <= '0;
  end

  // R4
  sil_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> (qn < QLIM));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && line_active && phy_ok) |=> link_ready);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R3
  req_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !link_ready);

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(init_seen && phy_ok));

  // R7
  change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready != $past(link_ready)) |-> chg_flag);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !irq_clr) |=> chg_flag);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
endmodule

bind link_hotplug_ctrl link_hotplug_ctrl_chk #(
  .RETRY_CYC(RETRY_CYC),
  .SIL_CYC  (SIL_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_active(line_active),
  .init_seen  (init_seen),
  .phy_ok     (phy_ok),
  .irq_en     (irq_en),
  .irq_clr    (irq_clr),
  .reset_req  (reset_req),
  .link_ready (link_ready),
  .chg_flag   (chg_flag),
  .irq_o      (irq_o)
);

// File: tb/link_hotplug_ctrl_tb_top.sv
module link_hotplug_ctrl_tb_top;
  localparam int RC = 6;
  localparam int SC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_active = 1'b0, init_seen = 1'b0, phy_ok = 1'b0;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic reset_req, link_ready, chg_flag, irq_o;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  link_hotplug_ctrl #(.RETRY_CYC(RC), .SIL_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_active(line_active), .init_seen(init_seen),
    .phy_ok(phy_ok), .irq_en(irq_en), .irq_clr(irq_clr), .reset_req(reset_req),
    .link_ready(link_ready), .chg_flag(chg_flag), .irq_o(irq_o));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_active = 0; init_seen = 0; phy_ok = 0; irq_en = 0; irq_clr = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic go_ready();
    init_seen = 1; phy_ok = 1; line_active = 1;
    tick();
    init_seen = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    tick(); tick();
    chk("R1 reset ready", link_ready, 0);
    chk("R1 reset flag", chg_flag, 0);
    chk("R1 reset irq", irq_o, 0);
    chk("R1 reset req", reset_req, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 first request", reset_req, 1);
    chk("R1 ready after release", link_ready, 0);

    // R2: periodic requests
    for (int k = 1; k <= 3 * RC; k++) begin
      tick();
      chk($sformatf("R2 pulse k=%0d", k), reset_req, (k % RC == 0) ? 1 : 0);
    end

    // R3: init without phy_ok ignored
    init_seen = 1; phy_ok = 0;
    tick();
    chk("R3 init no phy", link_ready, 0);
    init_seen = 0;

    // R3: init at every retry phase
    for (int off = 0; off < RC; off++) begin
      do_reset();
      repeat (off) tick();
      go_ready();
      chk($sformatf("R3 ready off=%0d", off), link_ready, 1);
      chk($sformatf("R3 no pulse off=%0d", off), reset_req, 0);
      chk($sformatf("R7 rise flag off=%0d", off), chg_flag, 1);
    end

    // R4/R6: silence sweep
    for (int q = 1; q <= SC + 1; q++) begin
      do_reset();
      go_ready();
      tick(); tick();
      line_active = 0;
      for (int i = 1; i <= q; i++) begin
        tick();
        chk($sformatf("R4 q=%0d i=%0d", q, i), link_ready, (i < SC) ? 1 : 0);
        if (i == SC + 1) chk("R6 request after drop", reset_req, 1);
      end
      if (q < SC) begin
        line_active = 1;
        tick();
        line_active = 0;
        for (int i = 1; i < SC; i++) begin
          tick();
          chk($sformatf("R4 restart q=%0d i=%0d", q, i), link_ready, 1);
        end
      end
    end

    // R6: period after re-entry
    do_reset();
    go_ready();
    line_active = 0;
    repeat (SC) tick();
    chk("R6 dropped", link_ready, 0);
    chk("R7 fall flag", chg_flag, 1);
    for (int k = 0; k <= 2 * RC; k++) begin
      tick();
      chk($sformatf("R6 pulse k=%0d", k), reset_req, (k % RC == 0) ? 1 : 0);
    end

    // R5
    do_reset();
    go_ready();
    phy_ok = 0;
    tick();
    chk("R5 phy drop", link_ready, 0);

    // R8/R9 sweep
    for (int pre = 0; pre < 2; pre++)
      for (int clr = 0; clr < 2; clr++)
        for (int ev = 0; ev < 2; ev++)
          for (int en = 0; en < 2; en++) begin
            do_reset();
            go_ready();
            if (pre == 0) begin
              irq_clr = 1; tick(); irq_clr = 0;
            end
            irq_clr = clr[0]; irq_en = en[0]; phy_ok = ~ev[0]; line_active = 1;
            tick();
            irq_clr = 0;
            chk($sformatf("R8 flag p%0d c%0d e%0d n%0d", pre, clr, ev, en), chg_flag,
                (ev == 1 || (pre == 1 && clr == 0)) ? 1 : 0);
            chk($sformatf("R5 ready p%0d c%0d e%0d n%0d", pre, clr, ev, en), link_ready, 1 - ev);
            chk($sformatf("R9 irq p%0d c%0d e%0d n%0d", pre, clr, ev, en), irq_o,
                (en == 1 && (ev == 1 || (pre == 1 && clr == 0))) ? 1 : 0);
          end

    // R8 sticky, R9 enable does not touch flag
    do_reset();
    go_ready();
    irq_en = 0;
    repeat (5) tick();
    chk("R8 sticky", chg_flag, 1);
    chk("R9 masked", irq_o, 0);
    irq_en = 1; tick();
    chk("R9 enabled", irq_o, 1);
    irq_en = 0; tick();
    chk("R9 flag kept", chg_flag, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule